// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is a single transmit DMA channel. It walks a chain of descriptors held in memory. Each descriptor is four 32-bit words placed at consecutive word addresses:
- +0: the address of the next descriptor;
- +4: the byte address of the buffer;
- +8: the buffer length, with the byte count in the low 11 bits;
- +12: a control/status word.

The host starts the channel by writing the byte address of the first descriptor into the head register. For each descriptor the engine does the following:
- it fetches the four words;
- it confirms that the hardware-ownership flag is set;
- it streams the buffer bytes out on a valid/ready byte port and marks the final byte;
- it writes the control word back with ownership handed to software.

The engine then follows the next pointer. When the next pointer is zero, it flags end-of-queue in that write-back and goes idle.

A host-writable completion register holds the host's acknowledgements. A teardown request lets the channel finish the packet in flight and then stop. The engine marks that last release as torn down and loads a fixed sentinel into the completion register. Memory is reached through a single-outstanding request/grant port with read responses on a separate valid strobe.

Control word bit positions, which software decodes:

| Bit(s) | Meaning |
|---|---|
| 31 | start of packet |
| 30 | end of packet |
| 29 | owned by hardware |
| 28 | end of queue |
| 27 | teardown complete |
| 26 | CRC passed through |
| 20 | directed-port enable |
| 18:16 | egress port number |

Top module: `desc_dma_chan`

## Requirements
- R1: After reset the following are all 0: `busy`, `out_valid`, `mem_req`, `done_evt`, `err_evt` and `cp_rdata`.
- R2: A one-cycle `hp_wr` starts a walk at `hp_wdata` only when all three hold: `enable` is 1, the channel is idle, and `hp_wdata` is nonzero. `busy` is 1 on the following cycle. A zero address, or a write while `enable` is 0, leaves `busy` at 0.
- R3: For each descriptor the engine emits exactly N bytes, where N is the low 11 bits of word +8. Byte k is the memory byte at buffer address + k, and byte b of a memory word sits at bits 8b+7:8b. The byte address may be unaligned. `out_last` is 1 only on byte N−1. When N is 0, no byte is emitted.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R5: Every byte of a packet carries `out_port_en` equal to control bit 20 and `out_port` equal to control bits 18:16 of its descriptor.
- R6: The release writes word +12 with bit 29 cleared. Every other bit of the fetched word is kept, except that bits 28 and 27 may be added. `done_evt` pulses once per release.
- R7: After a release whose next pointer is nonzero, the engine proceeds to that descriptor. When the next pointer is zero, bit 28 is set in the write-back and the channel goes idle.
- R8: The next pointer is read again after the last byte and before the release. A pointer that became nonzero in the meantime suppresses bit 28, and the walk continues to the appended descriptor.
- R9: If a fetched control word has bit 29 clear, the engine emits no byte and writes nothing. It pulses `err_evt` and is idle in that same cycle.
- R10: On a teardown request (`td_req`), the packet in flight is completed. It is released with bit 27 set, and no further descriptor is fetched. `cp_rdata` becomes 0xFFFFFFFC. A request while idle only loads that value.
- R11: A host write to the completion register (`cp_wr`) appears on `cp_rdata` on the next cycle.
- R12: A head write while the channel is busy is ignored. The descriptor it names is never processed.
- R13: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_we` and `mem_addr` stay unchanged. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | channel enable; gates starting a walk |
| hp_wr | input | 1 | head register write strobe |
| hp_wdata | input | AW | first descriptor byte address |
| cp_wr | input | 1 | completion register write strobe |
| cp_wdata | input | AW | acknowledged descriptor address |
| cp_rdata | output | AW | completion register value |
| td_req | input | 1 | teardown request pulse |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | byte address, word aligned |
| mem_wdata | output | DW | write data |
| mem_gnt | input | 1 | request accepted this cycle |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | DW | read data |
| out_valid | output | 1 | byte valid |
| out_ready | input | 1 | byte accepted |
| out_data | output | 8 | byte |
| out_last | output | 1 | final byte of the packet |
| out_port_en | output | 1 | directed-port flag of the packet |
| out_port | output | 3 | egress port of the packet |
| done_evt | output | 1 | one-cycle pulse per release |
| err_evt | output | 1 | one-cycle pulse on an unowned descriptor |
| busy | output | 1 | channel is walking |

## Verification
The hardest case to reach is the append race. The next pointer of the last descriptor must change after its initial fetch but before its release. Only then does the re-read decide whether end-of-queue is written.

The bench holds `out_ready` low so that the final packet stalls with bytes still pending. It patches the next word in the memory model while the engine waits, then releases the stream. Teardown is reached the same way: the stream is stalled mid-packet while the request is raised. The offset and length sweep also throttles the grant and ready lines, so that every lane split meets back-pressure.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int CW_SOP_BIT    = 31;
  localparam int CW_EOP_BIT    = 30;
  localparam int CW_OWN_BIT    = 29;
  localparam int CW_EOQ_BIT    = 28;
  localparam int CW_TDC_BIT    = 27;
  localparam int CW_DIREN_BIT  = 20;
  localparam int CW_PORT_LSB   = 16;
  localparam int CW_PORT_W     = 3;
  localparam logic [31:0] TD_SENTINEL = 32'hFFFF_FFFC;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_BUF, ST_LEN, ST_MODE,
    ST_DATA, ST_PUSH, ST_DRAIN, ST_CHK, ST_WB
  } walk_st_t;
endpackage

// File: rtl/dmach_byte_ser.sv
module dmach_byte_ser #(
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int LW    = $clog2(LANES),
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [LW-1:0]     ld_lane,
  input  logic [CW-1:0]     ld_cnt,
  input  logic              ld_last,
  output logic              empty,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [7:0]        o_data,
  output logic              o_last
);
  logic [WORD_W-1:0] word_q;
  logic [LW-1:0]     lane_q;
  logic [CW-1:0]     rem_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      lane_q <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      lane_q <= ld_lane;
      rem_q  <= ld_cnt;
      last_q <= ld_last;
    end else if (o_valid && o_ready) begin
      lane_q <= lane_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign o_valid = (rem_q != '0);
  assign o_data  = word_q[8*lane_q +: 8];
  assign o_last  = last_q && (rem_q == CW'(1));
  assign empty   = (rem_q == '0);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last));
  // R3
  load_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ld |-> !o_valid);
endmodule

// File: rtl/dmach_cp_reg.sv
module dmach_cp_reg
  import dmach_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [AW-1:0] host_data,
  input  logic          td_done,
  output logic [AW-1:0] cp_q
);
  always_ff @(posedge clk) begin
    if (rst)          cp_q <= '0;
    else if (td_done) cp_q <= TD_SENTINEL[AW-1:0];
    else if (host_wr) cp_q <= host_data;
  end

  // R10
  sentinel_load_chk: assert property (@(posedge clk) disable iff (rst)
    td_done |=> cp_q == TD_SENTINEL[AW-1:0]);
  // R11
  host_write_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr && !td_done |=> cp_q == $past(host_data));
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          hp_wr,
  input  logic [AW-1:0] hp_wdata,
  input  logic          cp_wr,
  input  logic [AW-1:0] cp_wdata,
  output logic [AW-1:0] cp_rdata,
  input  logic          td_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          out_port_en,
  output logic [2:0]    out_port,
  output logic          done_evt,
  output logic          err_evt,
  output logic          busy
);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam int CW    = $clog2(LANES + 1);

  walk_st_t          st;
  logic [AW-1:0]     desc_q, nxt_q, buf_q;
  logic [LEN_W-1:0]  left_q;
  logic [DW-1:0]     mode_q, word_q;
  logic              rq, pend, td_pend;

  logic              accept, rsp, ser_empty, ld, ld_last, td_done;
  logic [CW-1:0]     room, cnt;
  logic [LEN_W-1:0]  cnt_ext;

  assign accept = rq && mem_gnt;
  assign rsp    = pend && mem_rvalid;

  // bytes available in the current word, bounded by the bytes still owed
  assign room    = CW'(LANES) - CW'(buf_q[LW-1:0]);
  assign cnt     = (left_q < LEN_W'(room)) ? CW'(left_q) : room;
  assign cnt_ext = LEN_W'(cnt);
  assign ld      = (st == ST_PUSH) && ser_empty;
  assign ld_last = (left_q == cnt_ext);

  assign td_done = td_pend && ((st == ST_IDLE) || (st == ST_WB && accept));

  always_comb begin
    mem_addr = desc_q;
    case (st)
      ST_BUF:         mem_addr = desc_q + AW'(LANES);
      ST_LEN:         mem_addr = desc_q + AW'(2 * LANES);
      ST_MODE, ST_WB: mem_addr = desc_q + AW'(3 * LANES);
      ST_DATA:        mem_addr = {buf_q[AW-1:LW], {LW{1'b0}}};
      default:        mem_addr = desc_q;
    endcase
  end

  always_comb begin
    mem_wdata = mode_q;
    mem_wdata[CW_OWN_BIT] = 1'b0;
    if (nxt_q == '0) mem_wdata[CW_EOQ_BIT] = 1'b1;
    if (td_pend)     mem_wdata[CW_TDC_BIT] = 1'b1;
  end

  assign mem_req = rq;
  assign mem_we  = (st == ST_WB);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      desc_q <= '0; nxt_q <= '0; buf_q <= '0; left_q <= '0;
      mode_q <= '0; word_q <= '0;
      rq <= 1'b0; pend <= 1'b0; td_pend <= 1'b0;
      done_evt <= 1'b0; err_evt <= 1'b0;
      out_port_en <= 1'b0; out_port <= '0;
    end else begin
      done_evt <= 1'b0;
      err_evt  <= 1'b0;
      if (td_req) td_pend <= 1'b1;
      if (accept) begin
        rq   <= 1'b0;
        pend <= !mem_we;
      end
      if (rsp) pend <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (td_pend) td_pend <= 1'b0;
          else if (hp_wr && enable && hp_wdata != '0) begin
            desc_q <= hp_wdata;
            st <= ST_NEXT;
            rq <= 1'b1;
          end
        end
        ST_NEXT: if (rsp) begin nxt_q <= mem_rdata[AW-1:0]; st <= ST_BUF; rq <= 1'b1; end
        ST_BUF:  if (rsp) begin buf_q <= mem_rdata[AW-1:0]; st <= ST_LEN; rq <= 1'b1; end
        ST_LEN:  if (rsp) begin left_q <= mem_rdata[LEN_W-1:0]; st <= ST_MODE; rq <= 1'b1; end
        ST_MODE: if (rsp) begin
          mode_q <= mem_rdata;
          if (!mem_rdata[CW_OWN_BIT]) begin
            err_evt <= 1'b1;
            st <= ST_IDLE;
          end else begin
            out_port_en <= mem_rdata[CW_DIREN_BIT];
            out_port    <= mem_rdata[CW_PORT_LSB +: CW_PORT_W];
            if (left_q == '0) st <= ST_DRAIN;
            else begin st <= ST_DATA; rq <= 1'b1; end
          end
        end
        ST_DATA: if (rsp) begin word_q <= mem_rdata; st <= ST_PUSH; end
        ST_PUSH: if (ser_empty) begin
          buf_q  <= buf_q + AW'(cnt);
          left_q <= left_q - cnt_ext;
          if (ld_last) st <= ST_DRAIN;
          else begin st <= ST_DATA; rq <= 1'b1; end
        end
        ST_DRAIN: if (ser_empty) begin st <= ST_CHK; rq <= 1'b1; end
        ST_CHK:  if (rsp) begin nxt_q <= mem_rdata[AW-1:0]; st <= ST_WB; rq <= 1'b1; end
        ST_WB: if (accept) begin
          done_evt <= 1'b1;
          if (td_pend) begin
            td_pend <= 1'b0;
            st <= ST_IDLE;
          end else if (nxt_q == '0) begin
            st <= ST_IDLE;
          end else begin
            desc_q <= nxt_q;
            st <= ST_NEXT;
            rq <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  dmach_byte_ser #(.WORD_W(DW)) u_ser (
    .clk(clk), .rst(rst),
    .ld(ld), .ld_word(word_q), .ld_lane(buf_q[LW-1:0]), .ld_cnt(cnt), .ld_last(ld_last),
    .empty(ser_empty),
    .o_valid(out_valid), .o_ready(out_ready), .o_data(out_data), .o_last(out_last)
  );

  dmach_cp_reg #(.AW(AW)) u_cp (
    .clk(clk), .rst(rst),
    .host_wr(cp_wr), .host_data(cp_wdata), .td_done(td_done), .cp_q(cp_rdata)
  );

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R13
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> !mem_req);
  // R6
  release_owner_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[CW_OWN_BIT]);
  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> !busy && !out_valid);
  // R6
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_evt, err_evt}));
endmodule

// File: tb/sim_desc_dma_chan.sv
module sim_desc_dma_chan;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, enable, hp_wr, cp_wr, td_req;
  logic [31:0] hp_wdata, cp_wdata, cp_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_ready, out_last, out_port_en, done_evt, err_evt, busy;
  logic [7:0]  out_data;
  logic [2:0]  out_port;

  desc_dma_chan u0 (.*);

  localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000, OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000, TDC = 32'h0800_0000, DEN = 32'h0010_0000;

  function automatic logic [7:0] bytev(input logic [31:0] a);
    return 8'(a * 5 + 1);
  endfunction

  // memory model
  logic [31:0] mem [0:255];
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  logic [31:0] cyc = '0;
  logic        stall_gnt = 1'b0;
  assign mem_gnt = !stall_gnt || (cyc[1:0] != 2'd0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {bytev(i*4+3), bytev(i*4+2), bytev(i*4+1), bytev(i*4)};
    end else begin
      if (bw_en) mem[bw_addr[9:2]] <= bw_data;
      if (mem_req && mem_gnt) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else begin mem_rvalid <= 1'b1; mem_rdata <= mem[mem_addr[9:2]]; end
      end
    end
  end

  // output recorder and ready driver
  logic        hold_ready = 1'b0, throttle = 1'b0;
  logic [7:0]  rec_d [0:255];
  logic        rec_l [0:255];
  logic        rec_pe[0:255];
  logic [2:0]  rec_p [0:255];
  int rec_n = 0, n_done = 0, n_err = 0, hold_bad = 0, ncyc = 0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_d = '0;
  logic        prev_l = 1'b0;

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    if (prev_stall && (!out_valid || out_data != prev_d || out_last != prev_l)) hold_bad <= hold_bad + 1;
    out_ready = !hold_ready && !(throttle && (ncyc % 3 == 1));
    prev_stall <= out_valid && !out_ready;
    prev_d <= out_data;
    prev_l <= out_last;
    if (out_valid && out_ready) begin
      rec_d[rec_n[7:0]]  <= out_data;
      rec_l[rec_n[7:0]]  <= out_last;
      rec_pe[rec_n[7:0]] <= out_port_en;
      rec_p[rec_n[7:0]]  <= out_port;
      rec_n <= rec_n + 1;
    end
    if (done_evt) n_done <= n_done + 1;
    if (err_evt)  n_err  <= n_err + 1;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(posedge clk); #1 bw_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] da, input logic [31:0] nx, input logic [31:0] ba,
                          input logic [31:0] ln, input logic [31:0] md);
    bw(da, nx); bw(da + 4, ba); bw(da + 8, ln); bw(da + 12, md);
  endtask

  task automatic head(input logic [31:0] a);
    @(negedge clk); hp_wr = 1'b1; hp_wdata = a;
    @(negedge clk); hp_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #600000;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + 1);
    $finish;
  end

  initial begin
    int base, dn0, p;
    logic [31:0] da, ba, md, ln, expw;
    bit ok;
    logic [7:0] gd, ed;
    rst = 1'b1; enable = 1'b1; hp_wr = 1'b0; hp_wdata = '0; cp_wr = 1'b0; cp_wdata = '0; td_req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !out_valid && !mem_req && !done_evt && !err_evt, "R1 idle outputs",
        {busy, out_valid, mem_req, done_evt, err_evt}, 0);
    chk(cp_rdata == 0, "R1 cp_rdata", cp_rdata, 0);

    // R3 R5 R6 R7 R13 sweep: byte offset 0..3, lengths 0..9
    for (int off = 0; off < 4; off++) begin
      stall_gnt = off[0];
      throttle  = off[1];
      for (int i = 0; i < 10; i++) begin
        da = 32'h100 + 16 * i;
        md = SOP | EOP | OWN | (i[0] ? DEN : 0) | (32'(i % 8) << 16) | 32'(i);
        put_desc(da, (i < 9) ? da + 16 : 0, 32'h200 + 16 * i + off, 32'(i), md);
      end
      base = rec_n; dn0 = n_done;
      head(32'h100);
      wait_idle();
      p = base;
      for (int i = 0; i < 10; i++) begin
        ok = 1; ba = 32'h200 + 16 * i + off; gd = 0; ed = 0;
        for (int b = 0; b < i; b++) begin
          if (rec_d[p[7:0]] != bytev(ba + b) || rec_l[p[7:0]] != (b == i - 1) ||
              rec_pe[p[7:0]] != i[0] || rec_p[p[7:0]] != 3'(i % 8)) begin
            ok = 0; gd = rec_d[p[7:0]]; ed = bytev(ba + b);
          end
          p++;
        end
        chk(ok, $sformatf("R3/R5 packet %0d offset %0d bytes", i, off), gd, ed);
        md = SOP | EOP | (i[0] ? DEN : 0) | (32'(i % 8) << 16) | 32'(i) | ((i == 9) ? EOQ : 0);
        chk(mem[(32'h10C + 16 * i) >> 2] == md, $sformatf("R6/R7 writeback %0d", i),
            mem[(32'h10C + 16 * i) >> 2], md);
      end
      chk(rec_n - base == 45, "R3 byte total", rec_n - base, 45);
      chk(n_done - dn0 == 10, "R6 done pulses", n_done - dn0, 10);
    end
    stall_gnt = 1'b0; throttle = 1'b0;
    chk(hold_bad == 0, "R4 stall hold", hold_bad, 0);

    // R8 append race and R12 head write while busy
    put_desc(32'h180, 0, 32'h300, 8, SOP | EOP | OWN | 8);
    put_desc(32'h1A0, 0, 32'h321, 3, SOP | EOP | OWN | 3);
    put_desc(32'h1C0, 0, 32'h340, 2, SOP | EOP | OWN | 2);
    base = rec_n; dn0 = n_done;
    hold_ready = 1'b1;
    head(32'h180);
    while (!out_valid) @(negedge clk);
    bw(32'h180, 32'h1A0);
    head(32'h1C0);
    chk(busy == 1, "R12 busy during walk", busy, 1);
    hold_ready = 1'b0;
    wait_idle();
    chk(mem[32'h18C >> 2] == (SOP | EOP | 8), "R8 no EOQ after append", mem[32'h18C >> 2], SOP | EOP | 8);
    chk(mem[32'h1AC >> 2] == (SOP | EOP | EOQ | 3), "R8 appended released", mem[32'h1AC >> 2], SOP | EOP | EOQ | 3);
    chk(rec_n - base == 11, "R8 byte total", rec_n - base, 11);
    chk(rec_d[(base + 8) & 255] == bytev(32'h321), "R8 appended first byte", rec_d[(base + 8) & 255], bytev(32'h321));
    chk(mem[32'h1CC >> 2] == (SOP | EOP | OWN | 2), "R12 ignored head untouched", mem[32'h1CC >> 2], SOP | EOP | OWN | 2);
    chk(n_done - dn0 == 2, "R6 done pulses race", n_done - dn0, 2);

    // R9 unowned descriptor
    put_desc(32'h1E0, 0, 32'h300, 4, SOP | EOP | 4);
    base = rec_n; dn0 = n_done; p = n_err;
    head(32'h1E0);
    wait_idle();
    chk(n_err - p == 1, "R9 err pulse", n_err - p, 1);
    chk(n_done - dn0 == 0 && rec_n == base, "R9 no bytes or release", rec_n - base, 0);
    chk(mem[32'h1EC >> 2] == (SOP | EOP | 4), "R9 word untouched", mem[32'h1EC >> 2], SOP | EOP | 4);

    // R10 teardown mid-packet
    put_desc(32'h100, 32'h110, 32'h300, 9, SOP | EOP | OWN | 9);
    put_desc(32'h110, 0, 32'h320, 2, SOP | EOP | OWN | 2);
    base = rec_n;
    hold_ready = 1'b1;
    head(32'h100);
    while (!out_valid) @(negedge clk);
    td_req = 1'b1; @(negedge clk); td_req = 1'b0;
    hold_ready = 1'b0;
    wait_idle();
    expw = SOP | EOP | TDC | 9;
    chk(mem[32'h10C >> 2] == expw, "R10 torn-down release", mem[32'h10C >> 2], expw);
    chk(mem[32'h11C >> 2] == (SOP | EOP | OWN | 2), "R10 next not fetched", mem[32'h11C >> 2], SOP | EOP | OWN | 2);
    chk(cp_rdata == 32'hFFFF_FFFC, "R10 sentinel", cp_rdata, 32'hFFFF_FFFC);
    chk(rec_n - base == 9, "R10 packet completed", rec_n - base, 9);

    // R11 host write, then R10 idle teardown
    @(negedge clk); cp_wr = 1'b1; cp_wdata = 32'h1234_5670;
    @(negedge clk); cp_wr = 1'b0;
    chk(cp_rdata == 32'h1234_5670, "R11 host write", cp_rdata, 32'h1234_5670);
    td_req = 1'b1; @(negedge clk); td_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(cp_rdata == 32'hFFFF_FFFC, "R10 idle sentinel", cp_rdata, 32'hFFFF_FFFC);

    // R2 start gating
    enable = 1'b0;
    head(32'h110);
    chk(busy == 0, "R2 disabled head ignored", busy, 0);
    enable = 1'b1;
    head(32'h0);
    chk(busy == 0, "R2 zero head ignored", busy, 0);
    @(negedge clk); hp_wr = 1'b1; hp_wdata = 32'h110;
    @(negedge clk); hp_wr = 1'b0;
    chk(busy == 1, "R2 start next cycle", busy, 1);
    wait_idle();
    chk(mem[32'h11C >> 2] == (SOP | EOP | EOQ | 2), "R7 single release", mem[32'h11C >> 2], SOP | EOP | EOQ | 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule